// File: doc/BRIEF.md
# Sample and Control Frame Serial Port Engine

This block is the device side of a synchronous serial link to a DSP host. It runs on the serial clock and marks frames with a sync pulse. In each frame it sends one 16-bit word out on its transmit line and takes one 16-bit word in on its receive line. On a fixed schedule it runs sample frames. These carry a converter sample in each direction, a level for a direct output pin toward the host, and GPIO status from the device. The host can also ask for an extra control frame. It does this by setting the least significant bit of the word it sends in a sample frame. The engine then fits a control frame into the middle of the next period.

On the parallel side, the engine takes an ADC sample and GPIO levels, directions and a status enable. It gives out the DAC sample from each received sample frame and holds the direct output pin. It also passes each received control word to a register unit. In the same control frame, it sends back the raw GPIO levels and the register unit's read byte.

Top module: `dsp_frame_port`

## Requirements
- R1: A sample-frame sync pulse occurs every 32 clock cycles and is high for exactly one cycle. The first one comes in the cycle after the first rising edge with reset low.
- R2: `fs_tx_o` and `fs_rx_o` are high in exactly the same cycles, for both sample frames and control frames.
- R3: A frame moves 16 bits, most significant first. In the 16 cycles after a sync cycle, `sd_tx_o` carries the outgoing word. `sd_rx_i` is captured at the rising edges that end those same 16 cycles. Outside frames, `sd_tx_o` is low.
- R4: If bit 0 of an incoming sample word is 1, a control-frame sync fires 48 cycles after the sync of that sample frame. This is 16 cycles after the next sample sync.
- R5: If bit 0 of an incoming sample word is 0, no control frame follows. When requests come in consecutive sample frames, the engine issues exactly one control frame per period.
- R6: An outgoing sample word holds the ADC sample in bits 15..2. Bit 1 is GPIO1's level and bit 0 is GPIO0's level, but only when `gpio_stat_en_i` is 1 and that GPIO's direction bit is 1 (input). Otherwise each of these bits is 0.
- R7: The outgoing word is taken from the parallel inputs in the sync cycle itself. Later changes during the frame do not alter it.
- R8: In the cycle after the last bit of an incoming sample word, `dac_sample_o` shows word bits 15..2 and `dac_valid_o` is high for that one cycle.
- R9: `direct_out_o` follows bit 1 of the most recent incoming sample word and holds between words.
- R10: An outgoing control word is {`gpio_in_i`[7:0], `reg_rdata_i`[7:0]}, taken in the control sync cycle. In the cycle after its last bit, the incoming control word appears on `cmd_word_o` and `cmd_valid_o` pulses high for one cycle.
- R11: Synchronous active-high reset clears the frame timing, any pending control request, `direct_out_o`, both valid strobes and the transmit line. A request received before reset produces no control frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous active-high reset |
| fs_tx_o | output | 1 | Frame sync for the device-to-host direction |
| fs_rx_o | output | 1 | Frame sync for the host-to-device direction |
| sd_tx_o | output | 1 | Serial data to the host |
| sd_rx_i | input | 1 | Serial data from the host |
| adc_sample_i | input | 14 | Converter sample to send in sample frames |
| gpio_in_i | input | 8 | GPIO pin levels |
| gpio_dir_i | input | 8 | GPIO direction, 1 = input |
| gpio_stat_en_i | input | 1 | Enables GPIO1/GPIO0 status in sample words |
| reg_rdata_i | input | 8 | Register unit read byte for control frames |
| dac_sample_o | output | 14 | Last received DAC sample |
| dac_valid_o | output | 1 | One-cycle strobe for a new DAC sample |
| direct_out_o | output | 1 | Direct output pin level |
| cmd_word_o | output | 16 | Last received control word |
| cmd_valid_o | output | 1 | One-cycle strobe for a new control word |

## Verification
The bench attacks the cycle where the last bit of a request-carrying sample word lands together with the sync of an already pending control frame. A design that clears its pending flag after setting it would drop every second request. A design that fires too soon would put the control sync in the same period, 16 cycles early. All inputs are randomised every cycle, so a design that samples the ADC or GPIO inputs after the sync cycle sends corrupted words. A reset applied while a request is pending checks that no leftover control frame appears and that the direct output falls low.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

    typedef enum logic [1:0] {
        LOAD_NONE = 2'd0,
        LOAD_PRI  = 2'd1,
        LOAD_SEC  = 2'd2
    } load_sel_e;

    // One GPIO status bit: visible only when enabled and the pin is an input.
    function automatic logic status_bit(input logic en, input logic dir_in, input logic level);
        return en & dir_in & level;
    endfunction

endpackage

// File: rtl/sfe_frame_timer.sv
module sfe_frame_timer #(
    parameter int PERIOD     = 32,
    parameter int SEC_OFFSET = 16,
    parameter int CNT_W      = $clog2(PERIOD)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             fs_pri_o,
    output logic             fs_sec_o
);

    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(PERIOD - 1);
    localparam logic [CNT_W-1:0] SEC_CNT  = CNT_W'(SEC_OFFSET);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pend;
    } timer_t;

    timer_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        fs_sec_o = s_q.pend && (s_q.cnt == SEC_CNT);
        s_d.cnt  = (s_q.cnt == LAST_CNT) ? '0 : s_q.cnt + 1'b1;
        // a single flag: a new request re-arms it, a fired control frame clears it
        s_d.pend = req_i | (s_q.pend & ~fs_sec_o);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.cnt  <= LAST_CNT;
            s_q.pend <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_o    = s_q.cnt;
    assign fs_pri_o = (s_q.cnt == '0);

endmodule

// File: rtl/sfe_tx_shifter.sv
module sfe_tx_shifter
    import sfe_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int GPIO_W = 8,
    parameter int SMP_W  = WORD_W - 2,
    parameter int RD_W   = WORD_W - GPIO_W
) (
    input  logic              clk,
    input  logic              rst,
    input  load_sel_e         load_i,
    input  logic [SMP_W-1:0]  adc_i,
    input  logic [GPIO_W-1:0] gpio_lvl_i,
    input  logic [GPIO_W-1:0] gpio_dir_i,
    input  logic              stat_en_i,
    input  logic [RD_W-1:0]   rdata_i,
    output logic              sd_o
);

    typedef struct packed {
        logic [WORD_W-1:0] sr;
    } tx_t;

    tx_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        case (load_i)
            LOAD_PRI: s_d.sr = {adc_i,
                                status_bit(stat_en_i, gpio_dir_i[1], gpio_lvl_i[1]),
                                status_bit(stat_en_i, gpio_dir_i[0], gpio_lvl_i[0])};
            LOAD_SEC: s_d.sr = {gpio_lvl_i, rdata_i};
            default:  s_d.sr = {s_q.sr[WORD_W-2:0], 1'b0};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.sr <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sd_o = s_q.sr[WORD_W-1];

endmodule

// File: rtl/sfe_rx_deframer.sv
module sfe_rx_deframer #(
    parameter int WORD_W     = 16,
    parameter int PERIOD     = 32,
    parameter int SEC_OFFSET = 16,
    parameter int CNT_W      = $clog2(PERIOD),
    parameter int SMP_W      = WORD_W - 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sd_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              fs_sec_i,
    output logic              req_o,
    output logic [SMP_W-1:0]  dac_o,
    output logic              dac_valid_o,
    output logic              dgpo_o,
    output logic [WORD_W-1:0] cmd_o,
    output logic              cmd_valid_o
);

    localparam logic [CNT_W-1:0] PRI_END = CNT_W'(WORD_W % PERIOD);
    localparam logic [CNT_W-1:0] SEC_END = CNT_W'((SEC_OFFSET + WORD_W) % PERIOD);

    typedef struct packed {
        logic [WORD_W-2:0] sr;
        logic              sec_act;
        logic [SMP_W-1:0]  dac;
        logic              dac_v;
        logic              dgpo;
        logic [WORD_W-1:0] cmd;
        logic              cmd_v;
    } rx_t;

    rx_t               s_d, s_q;
    logic [WORD_W-1:0] word;
    logic              pri_done;
    logic              sec_done;

    always_comb begin
        s_d      = s_q;
        word     = {s_q.sr, sd_i};
        pri_done = (cnt_i == PRI_END);
        sec_done = s_q.sec_act && (cnt_i == SEC_END);
        req_o    = pri_done & sd_i;

        s_d.sr    = word[WORD_W-2:0];
        s_d.dac_v = 1'b0;
        s_d.cmd_v = 1'b0;

        if (pri_done) begin
            s_d.dac   = word[WORD_W-1:2];
            s_d.dgpo  = word[1];
            s_d.dac_v = 1'b1;
        end
        if (sec_done) begin
            s_d.cmd   = word;
            s_d.cmd_v = 1'b1;
        end

        if (fs_sec_i) begin
            s_d.sec_act = 1'b1;
        end else if (sec_done) begin
            s_d.sec_act = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign dac_o       = s_q.dac;
    assign dac_valid_o = s_q.dac_v;
    assign dgpo_o      = s_q.dgpo;
    assign cmd_o       = s_q.cmd;
    assign cmd_valid_o = s_q.cmd_v;

endmodule

// File: rtl/dsp_frame_port.sv
module dsp_frame_port
    import sfe_pkg::*;
#(
    parameter int WORD_W     = 16,
    parameter int PERIOD     = 32,
    parameter int SEC_OFFSET = 16,
    parameter int GPIO_W     = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    output logic                       fs_tx_o,
    output logic                       fs_rx_o,
    output logic                       sd_tx_o,
    input  logic                       sd_rx_i,
    input  logic [WORD_W-3:0]          adc_sample_i,
    input  logic [GPIO_W-1:0]          gpio_in_i,
    input  logic [GPIO_W-1:0]          gpio_dir_i,
    input  logic                       gpio_stat_en_i,
    input  logic [WORD_W-GPIO_W-1:0]   reg_rdata_i,
    output logic [WORD_W-3:0]          dac_sample_o,
    output logic                       dac_valid_o,
    output logic                       direct_out_o,
    output logic [WORD_W-1:0]          cmd_word_o,
    output logic                       cmd_valid_o
);

    localparam int SMP_W = WORD_W - 2;
    localparam int RD_W  = WORD_W - GPIO_W;
    localparam int CNT_W = $clog2(PERIOD);

    logic [CNT_W-1:0] cnt_w;
    logic             fs_pri_w;
    logic             fs_sec_w;
    logic             req_w;
    load_sel_e        load_w;

    sfe_frame_timer #(
        .PERIOD     (PERIOD),
        .SEC_OFFSET (SEC_OFFSET),
        .CNT_W      (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .req_i    (req_w),
        .cnt_o    (cnt_w),
        .fs_pri_o (fs_pri_w),
        .fs_sec_o (fs_sec_w)
    );

    always_comb begin
        if (fs_pri_w) begin
            load_w = LOAD_PRI;
        end else if (fs_sec_w) begin
            load_w = LOAD_SEC;
        end else begin
            load_w = LOAD_NONE;
        end
    end

    sfe_tx_shifter #(
        .WORD_W (WORD_W),
        .GPIO_W (GPIO_W),
        .SMP_W  (SMP_W),
        .RD_W   (RD_W)
    ) u_tx (
        .clk        (clk),
        .rst        (rst),
        .load_i     (load_w),
        .adc_i      (adc_sample_i),
        .gpio_lvl_i (gpio_in_i),
        .gpio_dir_i (gpio_dir_i),
        .stat_en_i  (gpio_stat_en_i),
        .rdata_i    (reg_rdata_i),
        .sd_o       (sd_tx_o)
    );

    sfe_rx_deframer #(
        .WORD_W     (WORD_W),
        .PERIOD     (PERIOD),
        .SEC_OFFSET (SEC_OFFSET),
        .CNT_W      (CNT_W),
        .SMP_W      (SMP_W)
    ) u_rx (
        .clk         (clk),
        .rst         (rst),
        .sd_i        (sd_rx_i),
        .cnt_i       (cnt_w),
        .fs_sec_i    (fs_sec_w),
        .req_o       (req_w),
        .dac_o       (dac_sample_o),
        .dac_valid_o (dac_valid_o),
        .dgpo_o      (direct_out_o),
        .cmd_o       (cmd_word_o),
        .cmd_valid_o (cmd_valid_o)
    );

    assign fs_tx_o = fs_pri_w | fs_sec_w;
    assign fs_rx_o = fs_pri_w | fs_sec_w;

endmodule

// File: rtl/dsp_frame_port_chk.sv
module dsp_frame_port_chk #(
    parameter int PERIOD = 32
) (
    input logic clk,
    input logic rst,
    input logic fs_tx,
    input logic fs_pri,
    input logic fs_sec,
    input logic req,
    input logic dac_valid,
    input logic direct_out
);

    localparam int GAP_W = $clog2(PERIOD + 1);
    localparam int AGE_W = $clog2(2 * PERIOD + 1);

    logic             rst_d_q;
    logic             seen_q;
    logic [GAP_W-1:0] gap_q;
    logic [AGE_W-1:0] age_q;

    always_ff @(posedge clk) begin
        rst_d_q <= rst;
        if (rst) begin
            seen_q <= 1'b0;
            gap_q  <= '0;
            age_q  <= '0;
        end else begin
            if (fs_pri) begin
                seen_q <= 1'b1;
                gap_q  <= '0;
            end else if (gap_q < GAP_W'(PERIOD)) begin
                gap_q <= gap_q + 1'b1;
            end
            if (req) begin
                age_q <= AGE_W'(1);
            end else if (age_q != '0 && age_q < AGE_W'(2 * PERIOD)) begin
                age_q <= age_q + 1'b1;
            end
        end
    end

    p_fs_single_r1: assert property (@(posedge clk) disable iff (rst || rst_d_q)
        fs_tx |=> !fs_tx);

    p_pri_period_r1: assert property (@(posedge clk) disable iff (rst || rst_d_q)
        (fs_pri && seen_q) |-> (gap_q == GAP_W'(PERIOD - 1)));

    p_pri_due_r1: assert property (@(posedge clk) disable iff (rst || rst_d_q)
        (seen_q && gap_q == GAP_W'(PERIOD - 1)) |-> fs_pri);

    // R5 as well: a control sync without a request one period earlier fails here
    p_sec_timing_r4: assert property (@(posedge clk) disable iff (rst || rst_d_q)
        fs_sec |-> (age_q == AGE_W'(PERIOD)));

    p_sec_due_r4: assert property (@(posedge clk) disable iff (rst || rst_d_q)
        (age_q == AGE_W'(PERIOD)) |-> fs_sec);

    p_dac_pulse_r8: assert property (@(posedge clk) disable iff (rst || rst_d_q)
        dac_valid |=> !dac_valid);

    p_dgpo_hold_r9: assert property (@(posedge clk) disable iff (rst || rst_d_q)
        !dac_valid |-> $stable(direct_out));

endmodule

bind dsp_frame_port dsp_frame_port_chk #(.PERIOD(PERIOD)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .fs_tx      (fs_tx_o),
    .fs_pri     (fs_pri_w),
    .fs_sec     (fs_sec_w),
    .req        (req_w),
    .dac_valid  (dac_valid_o),
    .direct_out (direct_out_o)
);

// File: tb/test_dsp_frame_port.sv
module test_dsp_frame_port;

    localparam int PERIOD     = 32;
    localparam int SEC_OFFSET = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fs_tx, fs_rx, sd_tx;
    logic        sd_rx = 1'b0;
    logic [13:0] adc = '0;
    logic [7:0]  gin = '0;
    logic [7:0]  gdir = '0;
    logic        en = 1'b0;
    logic [7:0]  rdata = '0;
    logic [13:0] dac;
    logic        dac_v, dgpo, cmd_v;
    logic [15:0] cmd;

    dsp_frame_port i_dsp_frame_port (
        .clk            (clk),
        .rst            (rst),
        .fs_tx_o        (fs_tx),
        .fs_rx_o        (fs_rx),
        .sd_tx_o        (sd_tx),
        .sd_rx_i        (sd_rx),
        .adc_sample_i   (adc),
        .gpio_in_i      (gin),
        .gpio_dir_i     (gdir),
        .gpio_stat_en_i (en),
        .reg_rdata_i    (rdata),
        .dac_sample_o   (dac),
        .dac_valid_o    (dac_v),
        .direct_out_o   (dgpo),
        .cmd_word_o     (cmd),
        .cmd_valid_o    (cmd_v)
    );

    always #5 clk = ~clk;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // host and schedule model
    int          t;
    bit          pend_m, dgpo_m, in_frame, frm_sec, exp_dv, exp_cv;
    int          idx;
    int          req_mode;   // 0 never, 1 always, 2 random
    int          b1_mode;    // -1 random, else forced value of bit 1
    logic [15:0] host_w, got_w, exp_tx, exp_cmd;
    logic [13:0] exp_dac;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s t=%0d actual=%h expected=%h", req, t, act, exp);
        end
    endtask

    function automatic logic [15:0] pri_tx_word(input logic [13:0] a, input logic [7:0] lvl,
                                                input logic [7:0] dir, input logic e);
        return {a, e & dir[1] & lvl[1], e & dir[0] & lvl[0]};
    endfunction

    function automatic logic [15:0] pick_host_pri();
        logic [15:0] w;
        w = 16'($urandom);
        case (req_mode)
            0: w[0] = 1'b0;
            1: w[0] = 1'b1;
            default: w[0] = (($urandom % 3) == 0);
        endcase
        if (b1_mode >= 0) w[1] = b1_mode[0];
        return w;
    endfunction

    task automatic step();
        int    tm;
        bit    efp, efs;
        string rq;
        @(negedge clk);
        tm  = t % PERIOD;
        efp = (tm == 0);
        efs = (tm == SEC_OFFSET) && pend_m;
        rq  = efp ? "R1" : (efs ? "R4" : "R5");
        check(fs_tx === (efp | efs), rq, 32'(fs_tx), 32'(efp | efs));
        check(fs_rx === fs_tx, "R2", 32'(fs_rx), 32'(fs_tx));
        check(dgpo === dgpo_m, "R9", 32'(dgpo), 32'(dgpo_m));
        check(dac_v === exp_dv, "R8", 32'(dac_v), 32'(exp_dv));
        if (exp_dv) check(dac === exp_dac, "R8", 32'(dac), 32'(exp_dac));
        check(cmd_v === exp_cv, "R10", 32'(cmd_v), 32'(exp_cv));
        if (exp_cv) check(cmd === exp_cmd, "R10", 32'(cmd), 32'(exp_cmd));
        if (!in_frame) check(sd_tx === 1'b0, "R3", 32'(sd_tx), 32'd0);

        exp_dv = 1'b0;
        exp_cv = 1'b0;
        if (efs) pend_m = 1'b0;

        if (in_frame) begin
            got_w[15-idx] = sd_tx;
            sd_rx         = host_w[15-idx];
            idx++;
            if (idx == 16) begin
                in_frame = 1'b0;
                if (frm_sec) begin
                    check(got_w === exp_tx, "R10 R3", 32'(got_w), 32'(exp_tx));
                    exp_cv  = 1'b1;
                    exp_cmd = host_w;
                end else begin
                    check(got_w === exp_tx, "R6 R7 R3", 32'(got_w), 32'(exp_tx));
                    exp_dv  = 1'b1;
                    exp_dac = host_w[15:2];
                    dgpo_m  = host_w[1];
                    if (host_w[0]) pend_m = 1'b1;
                end
            end
        end else begin
            sd_rx = 1'b0;
        end

        // parallel inputs change every cycle; only the sync-cycle value may count (R7)
        adc   = 14'($urandom);
        gin   = 8'($urandom);
        gdir  = 8'($urandom);
        en    = 1'($urandom);
        rdata = 8'($urandom);

        if (efp | efs) begin
            in_frame = 1'b1;
            idx      = 0;
            frm_sec  = efs;
            if (efs) begin
                exp_tx = {gin, rdata};
                host_w = 16'($urandom);
            end else begin
                exp_tx = pri_tx_word(adc, gin, gdir, en);
                host_w = pick_host_pri();
            end
        end
        t++;
    endtask

    task automatic do_reset(input int n);
        rst   = 1'b1;
        sd_rx = 1'b0;
        repeat (n) @(negedge clk);
        check(fs_tx === 1'b0, "R11", 32'(fs_tx), 32'd0);
        check(dgpo === 1'b0, "R11", 32'(dgpo), 32'd0);
        check(dac_v === 1'b0, "R11", 32'(dac_v), 32'd0);
        check(cmd_v === 1'b0, "R11", 32'(cmd_v), 32'd0);
        check(sd_tx === 1'b0, "R11", 32'(sd_tx), 32'd0);
        rst      = 1'b0;
        t        = 0;
        pend_m   = 1'b0;
        dgpo_m   = 1'b0;
        in_frame = 1'b0;
        exp_dv   = 1'b0;
        exp_cv   = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        req_mode = 0;
        b1_mode  = -1;
        do_reset(3);

        // no requests: only sample frames (R5)
        repeat (8 * PERIOD) step();
        // request in every sample frame: back-to-back control frames (R4, R5)
        req_mode = 1;
        repeat (10 * PERIOD) step();
        // mixed traffic
        req_mode = 2;
        repeat (60 * PERIOD) step();
        // reset while a request is pending and the direct output is high (R11)
        req_mode = 1;
        b1_mode  = 1;
        repeat (PERIOD) step();
        while ((t % PERIOD) != SEC_OFFSET + 2) step();
        req_mode = 0;
        b1_mode  = -1;
        do_reset(2);
        repeat (4 * PERIOD) step();
        req_mode = 2;
        repeat (8 * PERIOD) step();

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule